// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the 8-bit arithmetic and logic unit of an accumulator-based processor core. In each cycle it takes an operation select, the accumulator value, a second operand and the current flag byte. On the next clock edge it presents three registered values: the new result, a write strobe for the destination register and the new flag byte. The decode stage owns the register file and uses these outputs to update the accumulator and the flags.

A separate mode input switches the unit to single-register increment and decrement. In that mode the operand input carries the register value. The result goes back to that register. Carry keeps its old value in this mode, and the other flags follow their own rules.

The flag byte uses fixed bit positions. Two of its bits are not owned by this unit and pass straight through. Compare runs the full subtraction but does not raise the write strobe. The decoder therefore keeps the accumulator unchanged while the flags still show the outcome.

Top module: `acc_alu8`

## Requirements
- R1: While rst_n is low, res_q, wr_q and flags_q are all 0.
- R2: Outputs are registered. Inputs sampled at one rising clock edge appear on res_q, wr_q and flags_q after that edge. The flag byte layout is: bit 0 carry C, bit 1 subtract N, bit 2 parity/overflow PV, bit 4 half-carry H, bit 6 zero Z, bit 7 sign S.
- R3: With step_mode=0, fn=0 gives acc+opnd and fn=1 gives acc+opnd+C_in. C is the carry out of bit 7. H is the carry out of bit 3.
- R4: With step_mode=0, fn=2 gives acc-opnd and fn=3 gives acc-opnd-C_in. C is the borrow out of bit 7. H is the borrow into bit 4.
- R5: fn=7 (compare) puts acc-opnd on res_q with the same flags as fn=2, and holds wr_q at 0. Every other operation drives wr_q to 1.
- R6: N is 1 for fn 2, 3 and 7. N is 0 for fn 0, 1, 4, 5 and 6. In step mode, N is 1 for decrement and 0 for increment.
- R7: For fn 0, 1, 2, 3 and 7, PV is 1 exactly when the signed two's-complement result overflows 8 bits.
- R8: fn=4 gives AND, fn=5 gives XOR and fn=6 gives OR. Each of these clears C and sets PV to 1 when the result has an even number of one bits. H is 1 for AND and 0 for XOR and OR.
- R9: In every mode, S equals result bit 7, and Z is 1 exactly when the 8-bit result is 0.
- R10: With step_mode=1, fn[0]=0 gives opnd+1 and fn[0]=1 gives opnd-1, and acc and fn[2:1] are ignored. wr_q is 1, and C equals C_in. H is the carry out of bit 3 on increment and the borrow into bit 4 on decrement. PV is signed overflow.
- R11: Flag bits 3 and 5 of flags_q equal bits 3 and 5 of flags_in in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_mode | input | 1 | 1 selects register increment/decrement |
| fn | input | 3 | Operation select |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand, or the register value in step mode |
| flags_in | input | 8 | Current flag byte |
| res_q | output | 8 | Registered result |
| wr_q | output | 1 | Registered destination write strobe |
| flags_q | output | 8 | Registered new flag byte |

## Verification
The flag layout fixes the data path at 8 bits, so the unit has no free parameters and the bench builds the only configuration there is. Directed vectors reach each flag boundary: 0x7F+1, 0x80-1, nibble carries and borrows, results of zero and parity extremes. A long random run then covers all ten operation forms with random carry-in and random pass-through bits. Each result is compared with a behavioural integer model one cycle after its inputs are applied.

// File: rtl/acc_alu8_pkg.sv
package acc_alu8_pkg;

    localparam int DW = 8;

    localparam int FL_C  = 0;
    localparam int FL_N  = 1;
    localparam int FL_PV = 2;
    localparam int FL_H  = 4;
    localparam int FL_Z  = 6;
    localparam int FL_S  = 7;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_ADC = 3'd1,
        FN_SUB = 3'd2,
        FN_SBC = 3'd3,
        FN_AND = 3'd4,
        FN_XOR = 3'd5,
        FN_OR  = 3'd6,
        FN_CMP = 3'd7
    } fn_e;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        logic [DW-1:0] flags;
    } alu_out_t;

    function automatic logic [DW-1:0] pack_flags(
        input logic [DW-1:0] res,
        input logic          h,
        input logic          pv,
        input logic          n,
        input logic          c,
        input logic [DW-1:0] fin
    );
        logic [DW-1:0] f;
        f        = fin;
        f[FL_S]  = res[DW-1];
        f[FL_Z]  = (res == '0);
        f[FL_H]  = h;
        f[FL_PV] = pv;
        f[FL_N]  = n;
        f[FL_C]  = c;
        return f;
    endfunction

endpackage

// File: rtl/acc_alu8_arith.sv
module acc_alu8_arith
    import acc_alu8_pkg::*;
(
    input  logic [2:0]    fn,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      out
);
    localparam int NW = DW / 2;

    logic          is_sub;
    logic          cin;
    logic          cin_eff;
    logic [DW-1:0] b_eff;
    logic [DW:0]   sum;
    logic [NW:0]   nib;
    logic          h;
    logic          c;
    logic          ov;

    always_comb begin
        is_sub  = (fn == FN_SUB) || (fn == FN_SBC) || (fn == FN_CMP);
        cin     = ((fn == FN_ADC) || (fn == FN_SBC)) && flags_in[FL_C];
        b_eff   = is_sub ? ~opnd : opnd;
        cin_eff = is_sub ? ~cin : cin;
        sum     = {1'b0, acc} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
        nib     = {1'b0, acc[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin_eff};
        c       = is_sub ? ~sum[DW] : sum[DW];
        h       = is_sub ? ~nib[NW] : nib[NW];
        ov      = (acc[DW-1] == b_eff[DW-1]) && (sum[DW-1] != acc[DW-1]);
        out.res   = sum[DW-1:0];
        out.wr    = (fn != FN_CMP);
        out.flags = pack_flags(sum[DW-1:0], h, ov, is_sub, c, flags_in);
    end

endmodule

// File: rtl/acc_alu8_logic.sv
module acc_alu8_logic
    import acc_alu8_pkg::*;
(
    input  logic [1:0]    sel,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      out
);
    logic [DW-1:0] r;

    always_comb begin
        unique case (sel)
            2'd0:    r = acc & opnd;
            2'd1:    r = acc ^ opnd;
            default: r = acc | opnd;
        endcase
        out.res   = r;
        out.wr    = 1'b1;
        out.flags = pack_flags(r, (sel == 2'd0), ~(^r), 1'b0, 1'b0, flags_in);
    end

endmodule

// File: rtl/acc_alu8_step.sv
module acc_alu8_step
    import acc_alu8_pkg::*;
(
    input  logic          dec,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] flags_in,
    output alu_out_t      out
);
    localparam int            NW      = DW / 2;
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] r;
    logic          h;
    logic          ov;

    always_comb begin
        if (dec) begin
            r  = opnd - 1'b1;
            h  = (opnd[NW-1:0] == '0);
            ov = (opnd == NEG_MIN);
        end else begin
            r  = opnd + 1'b1;
            h  = (opnd[NW-1:0] == '1);
            ov = (opnd == POS_MAX);
        end
        out.res   = r;
        out.wr    = 1'b1;
        out.flags = pack_flags(r, h, ov, dec, flags_in[FL_C], flags_in);
    end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
    import acc_alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_mode,
    input  logic [2:0]    fn,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  logic [DW-1:0] flags_in,
    output logic [DW-1:0] res_q,
    output logic          wr_q,
    output logic [DW-1:0] flags_q
);
    alu_out_t arith_o;
    alu_out_t logic_o;
    alu_out_t step_o;
    alu_out_t nxt_d;
    alu_out_t nxt_q;

    acc_alu8_arith u_arith (
        .fn       (fn),
        .acc      (acc),
        .opnd     (opnd),
        .flags_in (flags_in),
        .out      (arith_o)
    );

    acc_alu8_logic u_logic (
        .sel      (fn[1:0]),
        .acc      (acc),
        .opnd     (opnd),
        .flags_in (flags_in),
        .out      (logic_o)
    );

    acc_alu8_step u_step (
        .dec      (fn[0]),
        .opnd     (opnd),
        .flags_in (flags_in),
        .out      (step_o)
    );

    always_comb begin
        if (step_mode) begin
            nxt_d = step_o;
        end else if (fn[2] && (fn != FN_CMP)) begin
            nxt_d = logic_o;
        end else begin
            nxt_d = arith_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q <= '0;
        end else begin
            nxt_q <= nxt_d;
        end
    end

    assign res_q   = nxt_q.res;
    assign wr_q    = nxt_q.wr;
    assign flags_q = nxt_q.flags;

endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk
    import acc_alu8_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          step_mode,
    input logic [2:0]    fn,
    input logic [DW-1:0] acc,
    input logic [DW-1:0] opnd,
    input logic [DW-1:0] flags_in,
    input logic [DW-1:0] res_q,
    input logic          wr_q,
    input logic [DW-1:0] flags_q
);
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!step_mode && fn == FN_CMP)) |-> !wr_q);

    p_sub_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!step_mode)) |->
        (flags_q[FL_N] == $past(fn == FN_SUB || fn == FN_SBC || fn == FN_CMP)));

    p_logic_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!step_mode && fn[2] && fn != FN_CMP)) |->
        (!flags_q[FL_C] && wr_q));

    p_sign_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (flags_q[FL_S] == res_q[DW-1] && flags_q[FL_Z] == (res_q == '0)));

    p_step_keeps_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(step_mode)) |->
        (flags_q[FL_C] == $past(flags_in[FL_C]) && wr_q &&
         flags_q[FL_N] == $past(fn[0])));

    p_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (flags_q[3] == $past(flags_in[3]) && flags_q[5] == $past(flags_in[5])));

endmodule

bind acc_alu8 acc_alu8_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_mode (step_mode),
    .fn        (fn),
    .acc       (acc),
    .opnd      (opnd),
    .flags_in  (flags_in),
    .res_q     (res_q),
    .wr_q      (wr_q),
    .flags_q   (flags_q)
);

// File: tb/acc_alu8_tb.sv
module acc_alu8_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_mode = 1'b0;
    logic [2:0] fn = '0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic [7:0] flags_in = '0;
    logic [7:0] res_q;
    logic       wr_q;
    logic [7:0] flags_q;

    int vectors = 0;
    int misses  = 0;

    always #2 clk = ~clk;

    acc_alu8 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_mode (step_mode),
        .fn        (fn),
        .acc       (acc),
        .opnd      (opnd),
        .flags_in  (flags_in),
        .res_q     (res_q),
        .wr_q      (wr_q),
        .flags_q   (flags_q)
    );

    function automatic int sx(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Reference model: returns {res[16:9], wr[8], flags[7:0]}
    function automatic logic [16:0] model(input logic sm, input int f, input int a,
                                          input int b, input int fi);
        int r, c, h, pv, n, wr, t, ci;
        c = fi & 1; h = 0; pv = 0; n = 0; wr = 1; r = 0;
        if (sm) begin
            if (f % 2 == 0) begin
                t = b + 1; h = ((b % 16) + 1) > 15; pv = (sx(b) + 1) > 127;
            end else begin
                t = b - 1; h = ((b % 16) - 1) < 0; pv = (sx(b) - 1) < -128; n = 1;
            end
            r = t & 255;
        end else if (f <= 1) begin
            ci = (f == 1) ? (fi & 1) : 0;
            t = a + b + ci; r = t & 255; c = t > 255;
            h = ((a % 16) + (b % 16) + ci) > 15;
            t = sx(a) + sx(b) + ci; pv = (t > 127) || (t < -128);
        end else if (f == 2 || f == 3 || f == 7) begin
            ci = (f == 3) ? (fi & 1) : 0;
            t = a - b - ci; r = t & 255; c = t < 0;
            h = ((a % 16) - (b % 16) - ci) < 0;
            t = sx(a) - sx(b) - ci; pv = (t > 127) || (t < -128);
            n = 1; wr = (f != 7);
        end else begin
            if (f == 4) begin r = a & b; h = 1; end
            else if (f == 5) r = a ^ b;
            else r = a | b;
            c = 0; pv = (ones(r) % 2) == 0;
        end
        t = (fi & 8'h28) | ((r >= 128) ? 8'h80 : 0) | ((r == 0) ? 8'h40 : 0) |
            (h ? 8'h10 : 0) | (pv ? 8'h04 : 0) | (n ? 8'h02 : 0) | (c ? 8'h01 : 0);
        return {r[7:0], wr[0], t[7:0]};
    endfunction

    function automatic string tag_of(input logic sm, input int f);
        if (sm) return "R10";
        if (f <= 1) return "R3";
        if (f <= 3) return "R4";
        if (f == 7) return "R5";
        return "R8";
    endfunction

    task automatic run(input logic sm, input int f, input int a, input int b, input int fi);
        logic [16:0] exp_v;
        @(negedge clk);
        step_mode = sm; fn = f[2:0]; acc = a[7:0]; opnd = b[7:0]; flags_in = fi[7:0];
        exp_v = model(sm, f, a, b, fi);
        @(negedge clk);
        vectors++;
        if ({res_q, wr_q, flags_q} !== exp_v) begin
            misses++;
            $display("FAIL %s sm=%0d fn=%0d a=%02h b=%02h f=%02h: got res=%02h wr=%0d fl=%02h exp res=%02h wr=%0d fl=%02h",
                     tag_of(sm, f), sm, f, a, b, fi, res_q, wr_q, flags_q,
                     exp_v[16:9], exp_v[8], exp_v[7:0]);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL R2 watchdog expired: got hang exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        flags_in = 8'hFF; acc = 8'h55; opnd = 8'hAA;
        repeat (3) @(negedge clk);
        // R1: reset state
        vectors++;
        if (res_q !== 8'h00 || wr_q !== 1'b0 || flags_q !== 8'h00) begin
            misses++;
            $display("FAIL R1 reset: got res=%02h wr=%0d fl=%02h exp 00 0 00", res_q, wr_q, flags_q);
        end
        rst_n = 1'b1;

        // R2/R3/R7: carry and overflow at 0x7F+1, nibble carry
        run(0, 0, 8'h7F, 8'h01, 8'h00);
        run(0, 0, 8'hFF, 8'h01, 8'h00);   // R9 zero result, full carry
        run(0, 1, 8'h0F, 8'h00, 8'h01);   // adc half carry via carry-in
        run(0, 1, 8'h80, 8'h80, 8'h01);   // R7 negative overflow
        // R4/R6/R7: borrow, half-borrow, overflow at 0x80-1
        run(0, 2, 8'h80, 8'h01, 8'h00);
        run(0, 2, 8'h00, 8'h01, 8'h00);
        run(0, 3, 8'h10, 8'h00, 8'h01);
        run(0, 3, 8'h00, 8'hFF, 8'h01);
        // R5: compare equal and less
        run(0, 7, 8'h42, 8'h42, 8'h00);
        run(0, 7, 8'h10, 8'h20, 8'hFF);
        // R8: logic ops, parity extremes
        run(0, 4, 8'hF0, 8'h0F, 8'h01);
        run(0, 5, 8'hFF, 8'h01, 8'h01);
        run(0, 6, 8'h00, 8'h07, 8'h01);
        // R10: step mode boundaries, fn[2:1] and acc ignored, C kept
        run(1, 0, 8'h12, 8'h7F, 8'h01);
        run(1, 1, 8'h34, 8'h80, 8'h00);
        run(1, 6, 8'h56, 8'hFF, 8'h01);
        run(1, 7, 8'h78, 8'h01, 8'h00);
        run(1, 3, 8'h9A, 8'h10, 8'hFE);
        // R11: pass-through bits with every other flag set
        run(0, 0, 8'h00, 8'h00, 8'hFF);
        run(0, 5, 8'h00, 8'h00, 8'h28);

        for (int i = 0; i < 20000; i++) begin
            run(logic'($urandom_range(0, 4) == 0), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                int'($urandom_range(0, 255)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule